// File: doc/BRIEF.md
# Programmable Reload Timer

An 8-bit up-counting timer controlled through a small register file. Software loads a start value, picks a tick rate from a power-of-two prescaler and starts the counter with an enable bit. A period ends in one of two ways. In overflow mode the counter passes 0xFF. In compare mode it reaches a programmed terminal value, having counted up from zero.

Each expiry does three things. It produces a one-cycle pulse, it sets a sticky interrupt flag, and it can drive an output pin high, drive it low or toggle it. In periodic operation the counter restarts by itself: from the stored start value in overflow mode, or from zero in compare mode. In one-shot operation the timer stops itself and holds its count. The live count can be read back at any time. The pin toggle mode together with periodic reload gives a square wave without any software action.

Top module: `reload_timer`

## Requirements
- R1: After a synchronous active-low reset, every readable register reads 0, and `expire`, `irq_flag` and `pin_out` are 0.
- R2: Registers are at these addresses: 0 is the start value (write) and the live count (read), 1 is control, 2 is the terminal value, and 3 is status with the flag in bit 0. A write to address 0 stores the start value. In the same cycle it sets the count to that value in overflow mode, or to 0 in compare mode. The read data shows the new count in the cycle after the write.
- R3: The control byte holds these fields: pin action in [7:6], prescale code in [5:3], compare mode in [2], periodic in [1] and enable in [0]. Prescale codes 0, 1, 2 and 3 divide the clock by 1, 8, 64 and 256. Codes 4 to 7 divide it by 1024. From an enabling write, the k-th count step happens k×divisor cycles later.
- R4: In overflow one-shot mode, the first tick taken at 0xFF is the expiry. The count stays at 0xFF, the enable bit reads 0 afterwards, and no further expiry occurs.
- R5: In overflow periodic mode, each expiry reloads the count with the start value. Expiries repeat every (256 − start)×divisor cycles.
- R6: In compare mode, the tick taken while the count equals the terminal value is the expiry. Periodic operation returns the count to 0 and repeats every (terminal+1)×divisor cycles. One-shot operation keeps the count at the terminal value and clears enable.
- R7: `expire` goes high for one cycle, in the cycle after the expiring tick. `irq_flag` rises in that same cycle and stays set. Writing status with bit 0 = 1 clears it, and writing 0 does not. If an expiry and a clear happen in the same cycle, the flag stays set.
- R8: The pin action code selects what an expiry does to `pin_out`, and the change shows in the same cycle as `expire`. Code 0 leaves the pin unchanged, 1 sets it to 1, 2 clears it to 0 and 3 inverts it.
- R9: While enable is 0, the count does not change and no expiry occurs, except through a write to address 0.
- R10: A write to address 0 takes priority over a tick in the same cycle. A control write takes priority over the self-clearing of enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| expire | output | 1 | One-cycle expiry pulse |
| irq_flag | output | 1 | Sticky expiry flag |
| pin_out | output | 1 | Pin driven by the expiry action |

## Verification
The assertions check a set of properties on every cycle. A count step adds exactly one. A stopped counter holds its value. A periodic overflow expiry reloads the start value, and a compare expiry returns to zero. A one-shot expiry drops enable. Every expiry pulse comes with a set flag, and a toggle action inverts the pin. A divided prescaler never ticks on two cycles in a row. Only the bench scenarios can show that the periods come out right as a product of start value or terminal value and divisor for each prescale code. The same goes for the cycle in which the first expiry lands after enabling, and for the long-term behaviour of one-shot stops and pin sequences.

// File: rtl/tmr_pkg.sv
// Package: shared types and helpers for the reload timer.
// Assumes an 8-bit control byte; field order is fixed by the register layout.
package tmr_pkg;

    typedef enum logic [1:0] {
        PIN_KEEP = 2'd0,
        PIN_SET  = 2'd1,
        PIN_CLR  = 2'd2,
        PIN_TGL  = 2'd3
    } pin_act_e;

    typedef enum logic [1:0] {
        ADR_LOAD = 2'd0,
        ADR_CTRL = 2'd1,
        ADR_TERM = 2'd2,
        ADR_STAT = 2'd3
    } reg_adr_e;

    // Control byte: [7:6] action, [5:3] prescale, [2] compare, [1] periodic, [0] enable
    typedef struct packed {
        pin_act_e   act;
        logic [2:0] psel;
        logic       cmp;
        logic       per;
        logic       en;
    } ctrl_t;

    // Log2 of the divide ratio selected by a prescale code
    function automatic int unsigned div_shift(input logic [2:0] sel);
        case (sel)
            3'd0:    return 0;
            3'd1:    return 3;
            3'd2:    return 6;
            3'd3:    return 8;
            default: return 10;
        endcase
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
// Module: tmr_prescaler
// Generates a one-cycle tick every 2^div_shift(sel) cycles while run is high.
// Assumes DIV_W >= 10 so the largest ratio fits; the phase restarts when run drops.
module tmr_prescaler
    import tmr_pkg::*;
#(
    parameter int DIV_W = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [2:0] sel,
    output logic       tick
);

    logic [DIV_W-1:0] pcnt;
    logic [DIV_W-1:0] mask;

    // Low-bit mask for the selected divide ratio
    always_comb mask = DIV_W'((32'd1 << div_shift(sel)) - 32'd1);

    // Tick when all selected low bits of the phase counter are ones
    always_comb tick = run && ((pcnt & mask) == mask);

    // Phase counter: runs while enabled, parked at zero otherwise
    always_ff @(posedge clk) begin
        if (!rst_n || !run) pcnt <= '0;
        else                pcnt <= pcnt + 1'b1;
    end

    // R3: with a ratio above one, ticks never fall on adjacent cycles
    a_r3_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (mask != '0) && run) |=> !tick);

endmodule

// File: rtl/tmr_count_core.sv
// Module: tmr_count_core
// Holds the start-value latch and the live count; decides expiry per mode.
// Assumes load writes and ticks may coincide; the load wins.
module tmr_count_core #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cmp_mode,
    input  logic             periodic,
    input  logic             load_wr,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] term,
    output logic [CNT_W-1:0] count,
    output logic             hit
);

    logic [CNT_W-1:0] start_q;
    logic             at_end;

    // End-of-period condition for the current mode
    always_comb at_end = cmp_mode ? (count == term) : (&count);

    // An expiry is a tick taken at the end of period
    always_comb hit = tick && at_end && !load_wr;

    // Start-value latch written by software
    always_ff @(posedge clk) begin
        if (!rst_n)       start_q <= '0;
        else if (load_wr) start_q <= load_val;
    end

    // Live count: load, reload on expiry, or step on tick
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (load_wr)
            count <= cmp_mode ? '0 : load_val;
        else if (hit) begin
            if (periodic) count <= cmp_mode ? '0 : start_q;
        end else if (tick)
            count <= count + 1'b1;
    end

    // R2: a non-expiring tick advances the count by one
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !at_end && !load_wr) |=> (count == $past(count) + 1'b1));

    // R9: without a tick or load the count is frozen
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load_wr) |=> $stable(count));

    // R5: periodic overflow expiry restores the start value
    a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && periodic && !cmp_mode) |=> (count == $past(start_q)));

    // R6: periodic compare expiry returns to zero
    a_r6_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && periodic && cmp_mode) |=> (count == '0));

endmodule

// File: rtl/tmr_event_out.sv
// Module: tmr_event_out
// Turns an expiry into a registered pulse, a sticky flag and a pin action.
// Assumes clr_flag is a single-cycle strobe from the status write.
module tmr_event_out
    import tmr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     hit,
    input  pin_act_e act,
    input  logic     clr_flag,
    output logic     expire,
    output logic     flag,
    output logic     pin
);

    // Registered expiry pulse
    always_ff @(posedge clk) begin
        if (!rst_n) expire <= 1'b0;
        else        expire <= hit;
    end

    // Sticky flag: set beats write-one-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n)        flag <= 1'b0;
        else if (hit)      flag <= 1'b1;
        else if (clr_flag) flag <= 1'b0;
    end

    // Pin action applied on each expiry
    always_ff @(posedge clk) begin
        if (!rst_n) pin <= 1'b0;
        else if (hit) begin
            case (act)
                PIN_SET:  pin <= 1'b1;
                PIN_CLR:  pin <= 1'b0;
                PIN_TGL:  pin <= ~pin;
                default:  pin <= pin;
            endcase
        end
    end

    // R7: a pulse is always accompanied by a set flag
    a_r7_flag_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> flag);

    // R7: a clear with no expiry empties the flag
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_flag && !hit) |=> !flag);

    // R8: toggle action inverts the pin on expiry
    a_r8_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && act == PIN_TGL) |=> (pin != $past(pin)));

endmodule

// File: rtl/reload_timer.sv
// Module: reload_timer (top)
// Register file plus prescaler, count core and expiry outputs of the timer.
// Assumes one write per cycle and a combinational read port.
module reload_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int DIV_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    output logic             expire,
    output logic             irq_flag,
    output logic             pin_out
);

    localparam int CTRL_W = $bits(ctrl_t);

    ctrl_t            ctrl;
    logic [CNT_W-1:0] term_q;
    logic [CNT_W-1:0] count;
    logic             tick;
    logic             hit;
    logic             wr_load, wr_ctrl, wr_term, wr_stat;

    // Write address decode
    always_comb begin
        wr_load = wr_en && (wr_addr == ADR_LOAD);
        wr_ctrl = wr_en && (wr_addr == ADR_CTRL);
        wr_term = wr_en && (wr_addr == ADR_TERM);
        wr_stat = wr_en && (wr_addr == ADR_STAT);
    end

    // Control register: software write wins over one-shot self-stop
    always_ff @(posedge clk) begin
        if (!rst_n)                  ctrl <= '0;
        else if (wr_ctrl)            ctrl <= ctrl_t'(wr_data[CTRL_W-1:0]);
        else if (hit && !ctrl.per)   ctrl.en <= 1'b0;
    end

    // Terminal value register
    always_ff @(posedge clk) begin
        if (!rst_n)       term_q <= '0;
        else if (wr_term) term_q <= wr_data;
    end

    // Read mux
    always_comb begin
        case (rd_addr)
            ADR_LOAD: rd_data = count;
            ADR_CTRL: rd_data = CNT_W'(ctrl);
            ADR_TERM: rd_data = term_q;
            default:  rd_data = {{(CNT_W-1){1'b0}}, irq_flag};
        endcase
    end

    tmr_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ctrl.en),
        .sel   (ctrl.psel),
        .tick  (tick)
    );

    tmr_count_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .cmp_mode (ctrl.cmp),
        .periodic (ctrl.per),
        .load_wr  (wr_load),
        .load_val (wr_data),
        .term     (term_q),
        .count    (count),
        .hit      (hit)
    );

    tmr_event_out u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .act      (ctrl.act),
        .clr_flag (wr_stat && wr_data[0]),
        .expire   (expire),
        .flag     (irq_flag),
        .pin      (pin_out)
    );

    // R4: one-shot expiry stops the timer unless software rewrites control
    a_r4_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !ctrl.per && !wr_ctrl) |=> !ctrl.en);

    // R10: a start-value write sets the count regardless of a coinciding tick
    a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_load |=> (count == ($past(ctrl.cmp) ? '0 : $past(wr_data))));

    // R9: a stopped timer never expires
    a_r9_no_expiry_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.en |=> !expire);

endmodule

// File: tb/reload_timer_bench.sv
module reload_timer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       expire, irq_flag, pin_out;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int last_wr_cyc = 0;
    bit done = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    reload_timer u_reload_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .expire(expire), .irq_flag(irq_flag), .pin_out(pin_out)
    );

    function automatic logic [7:0] mk_ctrl(input logic [1:0] act, input logic [2:0] ps,
                                           input logic cmp, input logic per, input logic en);
        return {act, ps, cmp, per, en};
    endfunction

    function automatic int div_of(input int code);
        case (code)
            0: return 1;
            1: return 8;
            2: return 64;
            3: return 256;
            default: return 1024;
        endcase
    endfunction

    function automatic int exp_period(input bit cmp, input int start, input int term, input int code);
        return (cmp ? (term + 1) : (256 - start)) * div_of(code);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
        last_wr_cyc = cyc;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        rd_addr = a; #1;
        v = rd_data;
    endtask

    task automatic wait_expire(input int max, output int at);
        at = -1;
        for (int i = 0; i < max; i++) begin
            @(negedge clk);
            if (expire) begin at = cyc; return; end
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        wait (cyc >= 190000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cyc, 190000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        int v, t0, t1, t2, e0, p, prev_pin;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v);
            check("R1 register read", v, 0);
        end
        check("R1 expire", expire, 0);
        check("R1 flag", irq_flag, 0);
        check("R1 pin", pin_out, 0);

        // R2: start-value write loads count; compare mode loads zero
        wr(2'd0, 8'h37);
        rd(2'd0, v); check("R2 load overflow mode", v, 8'h37);
        wr(2'd1, mk_ctrl(2'd0, 3'd0, 1'b1, 1'b0, 1'b0));
        wr(2'd0, 8'h55);
        rd(2'd0, v); check("R2 load compare mode", v, 0);

        // R4: overflow one-shot, divide by 1
        wr(2'd1, 8'h00);
        wr(2'd0, 8'hF0);
        wr(2'd1, mk_ctrl(2'd1, 3'd0, 1'b0, 1'b0, 1'b1));
        e0 = last_wr_cyc;
        wait_expire(400, t0);
        check("R4 first expiry cycle", t0 - e0, exp_period(0, 8'hF0, 0, 0));
        check("R7 flag with pulse", irq_flag, 1);
        check("R8 set action", pin_out, 1);
        rd(2'd1, v); check("R4 enable cleared", v & 1, 0);
        rd(2'd0, v); check("R4 count held", v, 8'hFF);
        @(negedge clk);
        check("R7 single cycle pulse", expire, 0);
        wait_expire(300, t1);
        check("R4 no second expiry", t1, -1);
        rd(2'd0, v); check("R9 stopped count held", v, 8'hFF);

        // R7: writing 0 keeps the flag, writing 1 clears it
        wr(2'd3, 8'h00);
        check("R7 write zero keeps flag", irq_flag, 1);
        wr(2'd3, 8'h01);
        check("R7 write one clears flag", irq_flag, 0);

        // R3: large prescale codes, two ticks from 0xFE
        for (int code = 2; code < 6; code++) begin
            wr(2'd1, 8'h00);
            wr(2'd0, 8'hFE);
            wr(2'd1, mk_ctrl(2'd0, code[2:0], 1'b0, 1'b0, 1'b1));
            e0 = last_wr_cyc;
            wait_expire(3000, t0);
            check($sformatf("R3 prescale code %0d", code), t0 - e0, exp_period(0, 8'hFE, 0, code));
        end

        // R5: periodic overflow, divide by 8
        wr(2'd1, 8'h00);
        wr(2'd0, 8'hC0);
        wr(2'd1, mk_ctrl(2'd0, 3'd1, 1'b0, 1'b1, 1'b1));
        e0 = last_wr_cyc;
        wait_expire(1000, t0);
        check("R5 first period", t0 - e0, exp_period(0, 8'hC0, 0, 1));
        rd(2'd0, v); check("R5 reload value", v, 8'hC0);
        wait_expire(1000, t1);
        check("R5 second period", t1 - t0, exp_period(0, 8'hC0, 0, 1));

        // R10: start-value write while running at divide by 1
        wr(2'd1, mk_ctrl(2'd0, 3'd0, 1'b0, 1'b1, 1'b1));
        wr(2'd0, 8'h80);
        rd(2'd0, v); check("R10 load beats tick", v, 8'h80);

        // R9: stop and observe the count frozen
        wr(2'd1, mk_ctrl(2'd0, 3'd0, 1'b0, 1'b1, 1'b0));
        rd(2'd0, t2);
        wait_expire(200, t1);
        check("R9 no expiry while stopped", t1, -1);
        rd(2'd0, v); check("R9 count frozen", v, t2);

        // R6: compare periodic with toggle action
        wr(2'd1, mk_ctrl(2'd0, 3'd0, 1'b1, 1'b0, 1'b0));
        wr(2'd0, 8'h00);
        wr(2'd2, 8'd9);
        prev_pin = pin_out;
        wr(2'd1, mk_ctrl(2'd3, 3'd0, 1'b1, 1'b1, 1'b1));
        e0 = last_wr_cyc;
        wait_expire(100, t0);
        check("R6 compare first period", t0 - e0, exp_period(1, 0, 9, 0));
        check("R8 toggle first", pin_out, prev_pin ^ 1);
        rd(2'd0, v); check("R6 count back to zero", v, 0);
        wait_expire(100, t1);
        check("R6 compare repeat period", t1 - t0, exp_period(1, 0, 9, 0));
        check("R8 toggle second", pin_out, prev_pin);

        // R6: compare one-shot holds at terminal; R8 clear action
        wr(2'd1, mk_ctrl(2'd0, 3'd0, 1'b1, 1'b0, 1'b0));
        wr(2'd0, 8'h00);
        wr(2'd2, 8'd5);
        wr(2'd1, mk_ctrl(2'd1, 3'd0, 1'b1, 1'b0, 1'b1));
        wait_expire(100, t0);
        check("R8 set before clear", pin_out, 1);
        wr(2'd1, mk_ctrl(2'd0, 3'd0, 1'b1, 1'b0, 1'b0));
        wr(2'd0, 8'h00);
        wr(2'd1, mk_ctrl(2'd2, 3'd0, 1'b1, 1'b0, 1'b1));
        e0 = last_wr_cyc;
        wait_expire(100, t0);
        check("R6 one-shot compare period", t0 - e0, exp_period(1, 0, 5, 0));
        check("R8 clear action", pin_out, 0);
        idle(4);
        rd(2'd0, v); check("R6 one-shot holds terminal", v, 5);
        rd(2'd1, v); check("R6 one-shot enable cleared", v & 1, 0);

        // R5/R6: random configurations, periods against the formula
        for (int k = 0; k < 10; k++) begin
            bit cmp;
            int st, tv, code;
            cmp  = 1'($urandom_range(0, 1));
            st   = $urandom_range(0, 8'hF0);
            tv   = $urandom_range(1, 8'h3F);
            code = $urandom_range(0, 1);
            wr(2'd1, mk_ctrl(2'd0, 3'd0, cmp, 1'b0, 1'b0));
            wr(2'd0, st[7:0]);
            wr(2'd2, tv[7:0]);
            wr(2'd1, mk_ctrl(2'd0, code[2:0], cmp, 1'b1, 1'b1));
            e0 = last_wr_cyc;
            p = exp_period(cmp, st, tv, code);
            wait_expire(p + 10, t0);
            check(cmp ? "R6 random first period" : "R5 random first period", t0 - e0, p);
            wait_expire(p + 10, t1);
            check(cmp ? "R6 random repeat period" : "R5 random repeat period", t1 - t0, p);
        end
        wr(2'd1, 8'h00);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule